// File: doc/BRIEF.md
# Segmented Virtual Address Translator

This block turns a 16-bit virtual address into a 22-bit physical address for a processor with three privilege levels. The virtual space is cut into eight segments, picked by the three top address bits. Each segment has two values held outside this block: a base in 64-byte units and a descriptor word.

The block drives a select index on its outputs. The register store outside the block uses that index to return the base and descriptor within the same cycle. The select index is made of the mode, the space (instruction or data) and the segment number. The block then forms the physical address and judges the access. It checks the offset against the segment length, taking account of whether the segment grows upward or downward. It also checks the access against a three-bit access code. The result is a hard abort, a watched-access trap, or a clean pass.

Results are registered and appear one clock after the request. When translation is switched off, the address passes through unmapped. In that case the top 8 KB of the virtual space lands on the top 8 KB of the physical space, which is the I/O page.

Top module: `seg_xlate`

## Requirements
- R1: The select outputs follow the inputs in the same cycle. `sel_seg` is `va[15:13]` and `sel_mode` is `mode`. `sel_dspace` is 1 only when the access is a data reference (`ispace`=0) and the split enable of the current mode is set. `split_en` bit 0 is kernel (mode 0), bit 1 is supervisor (mode 1) and bit 2 is user (mode 2). Mode 3 never selects data space.
- R2: With translation on, `pa` is (`base` × 64 + `va[12:0]`) modulo 2^22. It appears on the clock edge after the request.
- R3: A descriptor with bit 3 = 0 is an upward segment. It gives a length abort when `va[12:6]` is greater than descriptor bits 14:8.
- R4: A descriptor with bit 3 = 1 is a downward segment. It gives a length abort when `va[12:6]` is less than descriptor bits 14:8.
- R5: The access code in descriptor bits 2:0 behaves as follows. Codes 0, 3 and 7 abort every access. Code 1 aborts a write and traps a read. Code 2 aborts a write and passes a read. Code 4 traps every access. Code 5 traps a write and passes a read. Code 6 passes every access.
- R6: An access that would both abort and trap reports only the abort, and `trap` stays 0.
- R7: With translation off, there is no abort, no trap and `cause` is 0. `pa` is `va` zero-extended, except that when `va[15:13]` = 7, `pa` is `0x3FE000 | va[12:0]`.
- R8: `cause` bit 0 flags an access-code abort. Bit 1 flags a length abort. Bit 2 flags a reported trap. `abort` is 1 exactly when bit 0 or bit 1 is set.
- R9: While `rst_n` is low, `pa`, `abort`, `trap` and `cause` are all 0.
- R10: Mode value 3 is reserved. With translation on, it always gives an access-code abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| xlate_en | input | 1 | Translation enable |
| va | input | 16 | Virtual address |
| mode | input | 2 | 0 kernel, 1 supervisor, 2 user, 3 reserved |
| ispace | input | 1 | 1 for instruction-stream references (opcodes, immediates, absolute addresses) |
| wr | input | 1 | 1 for write, 0 for read |
| split_en | input | 3 | Per-mode split instruction/data enable |
| sel_mode | output | 2 | Register-set select: mode |
| sel_dspace | output | 1 | Register-set select: data space |
| sel_seg | output | 3 | Register-set select: segment |
| base | input | 16 | Base of the selected segment, in 64-byte units |
| desc | input | 16 | Descriptor of the selected segment |
| pa | output | 22 | Physical address, registered |
| abort | output | 1 | Access aborted, registered |
| trap | output | 1 | Watched-access trap, registered |
| cause | output | 3 | Fault cause flags, registered |

## Verification
Some behaviours are checked by the assertions on every cycle:
- abort and trap are never raised together;
- every abort carries a cause flag;
- an unmapped cycle never faults;
- the low offset bits pass straight through;
- upward and downward length violations always abort;
- a non-resident code always aborts.

Other behaviours can only be shown by the bench's scenarios, which compare each request against a behavioural model:
- the full access-code table for reads and writes;
- the exact boundary where the length check trips in each direction;
- the carry of base plus offset into the top bits;
- register-set selection across modes and split settings;
- the I/O-page relocation.

// File: rtl/segx_pkg.sv
package segx_pkg;
    localparam int VA_W     = 16;
    localparam int SEG_W    = 3;
    localparam int OFF_W    = VA_W - SEG_W;
    localparam int BLK_SH   = 6;
    localparam int BLK_W    = OFF_W - BLK_SH;
    localparam int DESC_W   = 16;
    localparam int LEN_LO   = 8;
    localparam int DIR_BIT  = 3;
    localparam int CODE_W   = 3;

    typedef enum logic [1:0] {
        MODE_KER = 2'd0,
        MODE_SUP = 2'd1,
        MODE_USR = 2'd2,
        MODE_RSV = 2'd3
    } cpu_mode_e;

    typedef enum logic [CODE_W-1:0] {
        ACC_ABSENT   = 3'd0,
        ACC_RO_WATCH = 3'd1,
        ACC_RO       = 3'd2,
        ACC_BAD3     = 3'd3,
        ACC_RW_WALL  = 3'd4,
        ACC_RW_WWR   = 3'd5,
        ACC_RW       = 3'd6,
        ACC_BAD7     = 3'd7
    } acc_code_e;

    typedef struct packed {
        logic       abort;
        logic       trap;
        logic [2:0] cause;
    } verdict_t;
endpackage

// File: rtl/seg_select.sv
module seg_select
    import segx_pkg::*;
(
    input  logic [1:0]       mode,
    input  logic             ispace,
    input  logic [2:0]       split_en,
    input  logic [VA_W-1:0]  va,
    output logic [1:0]       sel_mode,
    output logic             sel_dspace,
    output logic [SEG_W-1:0] sel_seg
);
    logic split_hit;

    always_comb begin
        unique case (cpu_mode_e'(mode))
            MODE_KER: split_hit = split_en[0];
            MODE_SUP: split_hit = split_en[1];
            MODE_USR: split_hit = split_en[2];
            default:  split_hit = 1'b0;
        endcase
    end

    assign sel_mode   = mode;
    assign sel_dspace = split_hit & ~ispace;
    assign sel_seg    = va[VA_W-1 -: SEG_W];
endmodule

// File: rtl/seg_guard.sv
module seg_guard
    import segx_pkg::*;
(
    input  logic [1:0]        mode,
    input  logic              wr,
    input  logic [DESC_W-1:0] desc,
    input  logic [BLK_W-1:0]  blk,
    output verdict_t          verdict
);
    logic [BLK_W-1:0] seg_len;
    logic             grows_down;
    logic             len_bad;
    logic             code_abort;
    logic             code_trap;
    logic             any_abort;
    logic             unused_desc;

    assign seg_len     = desc[LEN_LO +: BLK_W];
    assign grows_down  = desc[DIR_BIT];
    assign unused_desc = ^{desc[DESC_W-1], desc[DIR_BIT+4 -: 4]};

    always_comb begin
        if (grows_down) len_bad = (blk < seg_len);
        else            len_bad = (blk > seg_len);
    end

    always_comb begin
        code_abort = 1'b0;
        code_trap  = 1'b0;
        unique case (acc_code_e'(desc[CODE_W-1:0]))
            ACC_RO_WATCH: begin
                code_abort = wr;
                code_trap  = ~wr;
            end
            ACC_RO:      code_abort = wr;
            ACC_RW_WALL: code_trap  = 1'b1;
            ACC_RW_WWR:  code_trap  = wr;
            ACC_RW:      ;
            default:     code_abort = 1'b1;
        endcase
        if (cpu_mode_e'(mode) == MODE_RSV) code_abort = 1'b1;
    end

    assign any_abort     = code_abort | len_bad;
    assign verdict.abort = any_abort;
    assign verdict.trap  = code_trap & ~any_abort;
    assign verdict.cause = {code_trap & ~any_abort, len_bad, code_abort};
endmodule

// File: rtl/phys_form.sv
module phys_form
    import segx_pkg::*;
#(
    parameter int PA_W   = 22,
    parameter int BASE_W = 16
) (
    input  logic              xlate_en,
    input  logic [VA_W-1:0]   va,
    input  logic [BASE_W-1:0] base,
    output logic [PA_W-1:0]   pa
);
    localparam int HI_W = PA_W - OFF_W;

    logic [PA_W-1:0] mapped;
    logic [PA_W-1:0] flat;

    assign mapped = (PA_W'(base) << BLK_SH) + PA_W'(va[OFF_W-1:0]);

    always_comb begin
        if (&va[VA_W-1 -: SEG_W]) flat = {{HI_W{1'b1}}, va[OFF_W-1:0]};
        else                      flat = PA_W'(va);
    end

    assign pa = xlate_en ? mapped : flat;
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import segx_pkg::*;
#(
    parameter int PA_W   = 22,
    parameter int BASE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xlate_en,
    input  logic [15:0]       va,
    input  logic [1:0]        mode,
    input  logic              ispace,
    input  logic              wr,
    input  logic [2:0]        split_en,
    output logic [1:0]        sel_mode,
    output logic              sel_dspace,
    output logic [2:0]        sel_seg,
    input  logic [BASE_W-1:0] base,
    input  logic [15:0]       desc,
    output logic [PA_W-1:0]   pa,
    output logic              abort,
    output logic              trap,
    output logic [2:0]        cause
);
    verdict_t        chk_v;
    logic [PA_W-1:0] pa_nxt;

    seg_select u_sel (
        .mode       (mode),
        .ispace     (ispace),
        .split_en   (split_en),
        .va         (va),
        .sel_mode   (sel_mode),
        .sel_dspace (sel_dspace),
        .sel_seg    (sel_seg)
    );

    seg_guard u_guard (
        .mode    (mode),
        .wr      (wr),
        .desc    (desc),
        .blk     (va[OFF_W-1:BLK_SH]),
        .verdict (chk_v)
    );

    phys_form #(.PA_W(PA_W), .BASE_W(BASE_W)) u_form (
        .xlate_en (xlate_en),
        .va       (va),
        .base     (base),
        .pa       (pa_nxt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pa    <= '0;
            abort <= 1'b0;
            trap  <= 1'b0;
            cause <= '0;
        end else begin
            pa <= pa_nxt;
            if (xlate_en) begin
                abort <= chk_v.abort;
                trap  <= chk_v.trap;
                cause <= chk_v.cause;
            end else begin
                abort <= 1'b0;
                trap  <= 1'b0;
                cause <= '0;
            end
        end
    end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        xlate_en,
    input logic [15:0] va,
    input logic [15:0] desc,
    input logic [2:0]  sel_seg,
    input logic [21:0] pa,
    input logic        abort,
    input logic        trap,
    input logic [2:0]  cause
);
    AST_SEG_FROM_VA: assert property (@(posedge clk) disable iff (!rst_n)
        sel_seg == va[15:13]); // R1

    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(xlate_en) |-> pa[5:0] == $past(va[5:0])); // R2

    AST_UP_LEN_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(xlate_en && !desc[3] && (va[12:6] > desc[14:8])) |-> abort && cause[1]); // R3

    AST_DOWN_LEN_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(xlate_en && desc[3] && (va[12:6] < desc[14:8])) |-> abort && cause[1]); // R4

    AST_ABSENT_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(xlate_en && desc[2:0] == 3'd0) |-> abort && cause[0]); // R5

    AST_NO_DOUBLE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !(abort && trap)); // R6

    AST_FLAT_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(xlate_en) |-> !abort && !trap && cause == 3'd0); // R7

    AST_ABORT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> cause[1:0] != 2'b00); // R8

    AST_TRAP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> cause[2]); // R8
endmodule

bind seg_xlate seg_xlate_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .xlate_en (xlate_en),
    .va       (va),
    .desc     (desc),
    .sel_seg  (sel_seg),
    .pa       (pa),
    .abort    (abort),
    .trap     (trap),
    .cause    (cause)
);

// File: tb/seg_xlate_tb.sv
`timescale 1ns/100ps
module seg_xlate_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xlate_en = 1'b0;
    logic [15:0] va = '0;
    logic [1:0]  mode = '0;
    logic        ispace = 1'b0;
    logic        wr = 1'b0;
    logic [2:0]  split_en = '0;
    logic [1:0]  sel_mode;
    logic        sel_dspace;
    logic [2:0]  sel_seg;
    logic [15:0] base;
    logic [15:0] desc;
    logic [21:0] pa;
    logic        abort;
    logic        trap;
    logic [2:0]  cause;

    logic [15:0] st_base [64];
    logic [15:0] st_desc [64];

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    seg_xlate u_dut (
        .clk(clk), .rst_n(rst_n), .xlate_en(xlate_en), .va(va), .mode(mode),
        .ispace(ispace), .wr(wr), .split_en(split_en), .sel_mode(sel_mode),
        .sel_dspace(sel_dspace), .sel_seg(sel_seg), .base(base), .desc(desc),
        .pa(pa), .abort(abort), .trap(trap), .cause(cause)
    );

    always_comb begin
        base = st_base[{sel_mode, sel_dspace, sel_seg}];
        desc = st_desc[{sel_mode, sel_dspace, sel_seg}];
    end

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic set_seg(input int m, input int d, input int s, input int b, input int ds);
        st_base[m*16 + d*8 + s] = 16'(b);
        st_desc[m*16 + d*8 + s] = 16'(ds);
    endtask

    task automatic apply(input bit en, input int v, input int m, input bit isp,
                         input bit w, input int sp, input string tag);
        int  dsp, idx, b, ds, blk, len, code, e_pa, e_cause;
        bit  down, lf, aa, at, e_ab, e_tr;
        @(negedge clk);
        xlate_en = en; va = 16'(v); mode = 2'(m); ispace = isp; wr = w; split_en = 3'(sp);
        dsp = (m != 3 && ((sp >> m) & 1) == 1 && !isp) ? 1 : 0;
        #1;
        check({tag, " R1 sel"}, {sel_mode, sel_dspace, sel_seg}, m*16 + dsp*8 + ((v >> 13) & 7));
        if (!en) begin
            e_pa = (((v >> 13) & 7) == 7) ? (32'h3FE000 | (v & 8191)) : v;
            e_ab = 0; e_tr = 0; e_cause = 0;
        end else begin
            idx  = m*16 + dsp*8 + ((v >> 13) & 7);
            b    = st_base[idx];
            ds   = st_desc[idx];
            blk  = (v >> 6) & 127;
            len  = (ds >> 8) & 127;
            down = ((ds >> 3) & 1) == 1;
            lf   = down ? (blk < len) : (blk > len);
            code = ds & 7;
            aa = 0; at = 0;
            if (code == 0 || code == 3 || code == 7) aa = 1;
            else if (code == 1) begin aa = w; at = !w; end
            else if (code == 2) aa = w;
            else if (code == 4) at = 1;
            else if (code == 5) at = w;
            if (m == 3) aa = 1;
            e_ab = aa | lf;
            e_tr = at & !e_ab;
            e_cause = (e_tr ? 4 : 0) + (lf ? 2 : 0) + (aa ? 1 : 0);
            e_pa = (b * 64 + (v & 8191)) & 32'h3FFFFF;
        end
        @(posedge clk);
        #1;
        check({tag, " pa"}, pa, e_pa);
        check({tag, " abort"}, abort, e_ab);
        check({tag, " trap"}, trap, e_tr);
        check({tag, " cause"}, cause, e_cause);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin
            st_base[i] = 16'((i * 1237 + 341) & 16'hFFFF);
            st_desc[i] = 16'((((i * 37) & 127) << 8) | (((i >> 1) & 1) << 3) | (i & 7));
        end
        repeat (3) @(posedge clk);
        #1;
        check("R9 reset pa", pa, 0);
        check("R9 reset flags", {abort, trap, cause}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R7 untranslated: low and I/O page
        apply(0, 16'h1234, 0, 0, 0, 0, "R7 flat low");
        apply(0, 16'hE456, 2, 0, 1, 0, "R7 io page");
        apply(0, 16'hC000, 1, 1, 0, 7, "R7 below io");

        // R2 base plus offset, with carry into top bits
        set_seg(0, 0, 2, 16'hFFFF, 16'h7F06);
        apply(1, 16'h5FFF, 0, 1, 0, 0, "R2 carry wrap");
        set_seg(0, 0, 1, 16'h0100, 16'h7F06);
        apply(1, 16'h2040, 0, 1, 1, 0, "R2 plain");

        // R3 upward segment boundary
        set_seg(2, 0, 3, 16'h0200, 16'h1006);
        apply(1, 16'h6000 | (16 << 6) | 63, 2, 1, 0, 0, "R3 at limit");
        apply(1, 16'h6000 | (17 << 6), 2, 1, 0, 0, "R3 over limit");
        set_seg(2, 0, 4, 16'h0300, 16'h0006);
        apply(1, 16'h8000, 2, 1, 0, 0, "R3 zero length first block");

        // R4 downward segment boundary
        set_seg(1, 0, 5, 16'h0400, 16'h500E);
        apply(1, 16'hA000 | (80 << 6), 1, 1, 1, 0, "R4 at limit");
        apply(1, 16'hA000 | (79 << 6), 1, 1, 1, 0, "R4 below limit");
        apply(1, 16'hBFFF, 1, 1, 1, 0, "R4 top");

        // R5 and R6 every code, read and write, with and without length fault
        for (int c = 0; c < 8; c++) begin
            set_seg(0, 0, 6, 16'h0500 + c, 16'h7F00 | c);
            apply(1, 16'hC010, 0, 1, 0, 0, "R5 code read");
            apply(1, 16'hC010, 0, 1, 1, 0, "R5 code write");
            set_seg(0, 0, 6, 16'h0500 + c, 16'h0000 | c);
            apply(1, 16'hC100, 0, 1, 0, 0, "R6 code with length fault");
        end

        // R1 split selection per mode, I-stream versus data
        for (int m = 0; m < 4; m++) begin
            apply(1, 16'h2222, m, 0, 0, 3'b111, "R1 split data");
            apply(1, 16'h2222, m, 1, 0, 3'b111, "R1 split istream");
            apply(1, 16'h2222, m, 0, 0, 3'b000, "R1 no split data");
            apply(1, 16'h2222, m, 0, 0, 3'(1 << m), "R1 own split bit");
        end

        // R10 reserved mode
        set_seg(3, 0, 0, 16'h0010, 16'h7F06);
        apply(1, 16'h0100, 3, 1, 0, 0, "R10 reserved mode");

        // R8 mixed traffic
        for (int k = 0; k < 300; k++) begin
            apply($urandom_range(0, 7) != 0, $urandom_range(0, 65535), $urandom_range(0, 3),
                  $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 7), "R8 mixed");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule